// File: doc/BRIEF.md
# Lane-skipping 64-to-32 bus downsizer

This block joins a 64-bit single-beat master port to a 32-bit slave port. A wide request is split into at most two narrow cycles, one for each 32-bit half. A half is sent downstream only if at least one of its four byte selects is set. A write to one narrow register therefore never disturbs the register in the other half of the same wide word.

Write data and byte selects for each half are moved onto the narrow bus. Read data returned by each half is placed back in its own lane of the wide read bus. The master sees one acknowledge, or one error, once every needed half has finished. A request with no byte select set completes at once and the slave never sees it.

Top module: `wb_lane_downsizer`

## Requirements
- R1: A narrow cycle is issued only for a half whose byte selects (bits 3..0 for the low half, bits 7..4 for the high half) are not all zero. A narrow cycle never carries an all-zero select.
- R2: When both halves are needed, the low half runs first and the high half second. The narrow address is the wide word address with one bit appended below it: 0 for the low half and 1 for the high half.
- R3: For each half, the narrow select is the matching 4-bit slice of the wide select and the narrow write data is the matching 32-bit slice of the wide write data.
- R4: On a read, the 32-bit value returned by each finished half appears in the matching lane of the wide read data (low half in bits 31..0, high half in bits 63..32). A lane that was not read returns zero, and a write returns zero in both lanes.
- R5: The wide acknowledge is high for exactly one cycle. It arrives one cycle after the acknowledge of the last needed narrow cycle. Measured in clock edges from the edge that accepts the request, this is 1 + (L+1) per issued half, where L is the slave wait, plus 1 more when two halves run.
- R6: A request with all eight selects clear is acknowledged on the first edge after it is accepted, and no narrow cycle is issued.
- R7: A narrow error ends the sequence at once. Any remaining half is skipped. The wide port then sees a one-cycle error with no acknowledge.
- R8: A narrow cycle holds cyc, stb, address, select and write data steady until the slave answers. The narrow strobe drops for at least one cycle between the two halves and between requests.
- R9: After reset the narrow cyc and stb, the wide acknowledge and error, and the wide read data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_cyc | input | 1 | Wide bus cycle valid |
| up_stb | input | 1 | Wide bus strobe |
| up_we | input | 1 | Wide bus write enable |
| up_adr | input | ADR_W (28) | Wide word address |
| up_sel | input | UP_DW/8 (8) | Wide byte selects |
| up_dat_w | input | UP_DW (64) | Wide write data |
| up_dat_r | output | UP_DW (64) | Wide read data |
| up_ack | output | 1 | Wide acknowledge |
| up_err | output | 1 | Wide error |
| dn_cyc | output | 1 | Narrow bus cycle valid |
| dn_stb | output | 1 | Narrow bus strobe |
| dn_we | output | 1 | Narrow write enable |
| dn_adr | output | ADR_W+1 (29) | Narrow word address |
| dn_sel | output | DN_DW/8 (4) | Narrow byte selects |
| dn_dat_w | output | DN_DW (32) | Narrow write data |
| dn_dat_r | input | DN_DW (32) | Narrow read data |
| dn_ack | input | 1 | Narrow acknowledge |
| dn_err | input | 1 | Narrow error |

## Verification
The select patterns are full, low-only, high-only, a pattern that straddles the two halves, and all-clear. Together they separate a correct lane skip from a downsizer that always runs both halves, and they catch swapped or misaligned lane steering. Reads with one half skipped show whether the unused lane is zeroed. Slave waits of zero, one and two cycles test the fixed acknowledge timing. Errors injected on the low half and on the high half show whether the remaining half is dropped and whether error is reported in place of acknowledge.

// File: rtl/lane_dsz_pkg.sv
package lane_dsz_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_LO   = 3'd1,
      ST_GAP  = 3'd2,
      ST_HI   = 3'd3,
      ST_RESP = 3'd4
   } dsz_state_e;

endpackage

// File: rtl/dsz_seq_ctrl.sv
module dsz_seq_ctrl
   import lane_dsz_pkg::*;
#(
   parameter int SEL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [SEL_W-1:0] sel_in,
   input  logic             dn_ack,
   input  logic             dn_err,
   output dsz_state_e       state,
   output logic             err_flag,
   output logic             cap_lo,
   output logic             cap_hi
);

   localparam int HALF_SEL = SEL_W / 2;

   logic       have_bottom;
   logic       have_top;
   logic       top_q;
   dsz_state_e state_nx;

   assign have_bottom = |sel_in[HALF_SEL-1:0];
   assign have_top    = |sel_in[SEL_W-1:HALF_SEL];

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: begin
            if (req) begin
               if (have_bottom)   state_nx = ST_LO;
               else if (have_top) state_nx = ST_HI;
               else               state_nx = ST_RESP;
            end
         end
         ST_LO: begin
            if (dn_err)      state_nx = ST_RESP;
            else if (dn_ack) state_nx = top_q ? ST_GAP : ST_RESP;
         end
         ST_GAP:  state_nx = ST_HI;
         ST_HI: begin
            if (dn_err || dn_ack) state_nx = ST_RESP;
         end
         ST_RESP: state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         top_q    <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         state <= state_nx;
         if (state == ST_IDLE && req) begin
            top_q    <= have_top;
            err_flag <= 1'b0;
         end else if ((state == ST_LO || state == ST_HI) && dn_err) begin
            err_flag <= 1'b1;
         end
      end
   end

   assign cap_lo = (state == ST_LO) && dn_ack && !dn_err;
   assign cap_hi = (state == ST_HI) && dn_ack && !dn_err;

   // R7
   err_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LO && dn_err) |=> (state == ST_RESP && err_flag));

   // R6
   empty_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && req && !(|sel_in)) |=> (state == ST_RESP));

endmodule

// File: rtl/dsz_lane_steer.sv
module dsz_lane_steer #(
   parameter int IN_W  = 64,
   parameter int OUT_W = 32
) (
   input  logic [IN_W-1:0]  vec_in,
   input  logic             pick_hi,
   output logic [OUT_W-1:0] vec_out
);

   if (IN_W != 2 * OUT_W) begin : g_bad_ratio
      $error("dsz_lane_steer: IN_W must be twice OUT_W");
   end

   for (genvar b = 0; b < OUT_W; b++) begin : g_bit
      assign vec_out[b] = pick_hi ? vec_in[OUT_W + b] : vec_in[b];
   end

endmodule

// File: rtl/dsz_read_gather.sv
module dsz_read_gather #(
   parameter int DN_DW = 32,
   parameter int LANES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic [LANES-1:0]       cap,
   input  logic [DN_DW-1:0]       dn_dat,
   output logic [LANES*DN_DW-1:0] wide_dat
);

   if (LANES < 1) begin : g_bad_lanes
      $error("dsz_read_gather: LANES must be at least one");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DN_DW-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr) lane_q <= '0;
         else if (cap[l])   lane_q <= dn_dat;
      end
      assign wide_dat[l*DN_DW +: DN_DW] = lane_q;
   end

endmodule

// File: rtl/wb_lane_downsizer.sv
module wb_lane_downsizer
   import lane_dsz_pkg::*;
#(
   parameter int UP_DW = 64,
   parameter int DN_DW = 32,
   parameter int ADR_W = 28
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 up_cyc,
   input  logic                 up_stb,
   input  logic                 up_we,
   input  logic [ADR_W-1:0]     up_adr,
   input  logic [UP_DW/8-1:0]   up_sel,
   input  logic [UP_DW-1:0]     up_dat_w,
   output logic [UP_DW-1:0]     up_dat_r,
   output logic                 up_ack,
   output logic                 up_err,
   output logic                 dn_cyc,
   output logic                 dn_stb,
   output logic                 dn_we,
   output logic [ADR_W:0]       dn_adr,
   output logic [DN_DW/8-1:0]   dn_sel,
   output logic [DN_DW-1:0]     dn_dat_w,
   input  logic [DN_DW-1:0]     dn_dat_r,
   input  logic                 dn_ack,
   input  logic                 dn_err
);

   localparam int UP_SW = UP_DW / 8;
   localparam int DN_SW = DN_DW / 8;
   localparam int LANES = UP_DW / DN_DW;

   if (UP_DW != 2 * DN_DW) begin : g_bad_ratio
      $error("wb_lane_downsizer: only a 2:1 width ratio is supported");
   end
   if (DN_DW % 8 != 0) begin : g_bad_bytes
      $error("wb_lane_downsizer: DN_DW must be a whole number of bytes");
   end
   if (ADR_W < 1) begin : g_bad_adr
      $error("wb_lane_downsizer: ADR_W must be positive");
   end

   dsz_state_e           state;
   logic                 err_flag;
   logic                 cap_lo;
   logic                 cap_hi;
   logic                 accept;
   logic                 in_hi;
   logic                 active;
   logic [ADR_W-1:0]     adr_q;
   logic                 we_q;
   logic [UP_SW-1:0]     sel_q;
   logic [UP_DW-1:0]     wdat_q;
   logic [LANES-1:0]     cap_vec;

   assign accept = (state == ST_IDLE) && up_cyc && up_stb;
   assign in_hi  = (state == ST_HI);
   assign active = (state == ST_LO) || (state == ST_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         adr_q  <= '0;
         we_q   <= 1'b0;
         sel_q  <= '0;
         wdat_q <= '0;
      end else if (accept) begin
         adr_q  <= up_adr;
         we_q   <= up_we;
         sel_q  <= up_sel;
         wdat_q <= up_dat_w;
      end
   end

   dsz_seq_ctrl #(.SEL_W(UP_SW)) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (accept),
      .sel_in   (up_sel),
      .dn_ack   (dn_ack),
      .dn_err   (dn_err),
      .state    (state),
      .err_flag (err_flag),
      .cap_lo   (cap_lo),
      .cap_hi   (cap_hi)
   );

   dsz_lane_steer #(.IN_W(UP_DW), .OUT_W(DN_DW)) i_wdat_steer (
      .vec_in  (wdat_q),
      .pick_hi (in_hi),
      .vec_out (dn_dat_w)
   );

   dsz_lane_steer #(.IN_W(UP_SW), .OUT_W(DN_SW)) i_sel_steer (
      .vec_in  (sel_q),
      .pick_hi (in_hi),
      .vec_out (dn_sel)
   );

   assign cap_vec = {cap_hi && !we_q, cap_lo && !we_q};

   dsz_read_gather #(.DN_DW(DN_DW), .LANES(LANES)) i_gather (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .cap      (cap_vec),
      .dn_dat   (dn_dat_r),
      .wide_dat (up_dat_r)
   );

   assign dn_cyc = active;
   assign dn_stb = active;
   assign dn_we  = we_q;
   assign dn_adr = {adr_q, in_hi};
   assign up_ack = (state == ST_RESP) && !err_flag;
   assign up_err = (state == ST_RESP) && err_flag;

   // R1
   no_empty_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_stb |-> (dn_sel != '0));

   // R8
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_stb && !dn_ack && !dn_err) |=>
         (dn_stb && $stable(dn_adr) && $stable(dn_sel) && $stable(dn_dat_w)));

   // R8
   gap_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_stb && (dn_ack || dn_err)) |=> !dn_stb);

   // R5
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_ack |=> !up_ack);

   // R7
   ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_ack && up_err));

   // R2
   low_before_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_stb && !dn_adr[0] && dn_ack && sel_q[UP_SW-1:DN_SW] != '0) |=>
         ##1 (dn_stb && dn_adr[0]));

endmodule

// File: tb/test_wb_lane_downsizer.sv
module test_wb_lane_downsizer;

   localparam int UP_DW = 64;
   localparam int DN_DW = 32;
   localparam int ADR_W = 28;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              up_cyc = 1'b0, up_stb = 1'b0, up_we = 1'b0;
   logic [ADR_W-1:0]  up_adr = '0;
   logic [7:0]        up_sel = '0;
   logic [63:0]       up_dat_w = '0;
   logic [63:0]       up_dat_r;
   logic              up_ack, up_err;
   logic              dn_cyc, dn_stb, dn_we;
   logic [ADR_W:0]    dn_adr;
   logic [3:0]        dn_sel;
   logic [31:0]       dn_dat_w;
   logic [31:0]       dn_dat_r = '0;
   logic              dn_ack = 1'b0, dn_err = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;

   int slv_lat = 0;
   int inj_half = -1;
   int wcnt = 0;
   bit prev_stb = 1'b0;
   int log_n = 0;
   int rise_n = 0;
   logic [ADR_W:0] l_adr [4];
   logic [3:0]     l_sel [4];
   logic [31:0]    l_dat [4];

   always #10 clk = ~clk;

   wb_lane_downsizer #(.UP_DW(UP_DW), .DN_DW(DN_DW), .ADR_W(ADR_W)) i_wb_lane_downsizer (
      .clk(clk), .rst_n(rst_n),
      .up_cyc(up_cyc), .up_stb(up_stb), .up_we(up_we), .up_adr(up_adr),
      .up_sel(up_sel), .up_dat_w(up_dat_w), .up_dat_r(up_dat_r),
      .up_ack(up_ack), .up_err(up_err),
      .dn_cyc(dn_cyc), .dn_stb(dn_stb), .dn_we(dn_we), .dn_adr(dn_adr),
      .dn_sel(dn_sel), .dn_dat_w(dn_dat_w), .dn_dat_r(dn_dat_r),
      .dn_ack(dn_ack), .dn_err(dn_err)
   );

   function automatic logic [31:0] rd_val(input logic [ADR_W:0] a);
      return 32'h5A00_0000 | (32'(a) & 32'h00FF_FFFF) ^ 32'h0013_0000;
   endfunction

   // narrow slave model, answering after slv_lat wait cycles
   always @(negedge clk) begin
      dn_ack = 1'b0;
      dn_err = 1'b0;
      if (!rst_n) begin
         wcnt = 0;
         prev_stb = 1'b0;
      end else begin
         if (dn_cyc && dn_stb) begin
            if (!prev_stb) rise_n++;
            if (wcnt == slv_lat) begin
               wcnt = 0;
               if (inj_half == int'(dn_adr[0])) dn_err = 1'b1;
               else dn_ack = 1'b1;
               dn_dat_r = dn_we ? 32'hDEAD_BEEF : rd_val(dn_adr);
               if (log_n < 4) begin
                  l_adr[log_n] = dn_adr;
                  l_sel[log_n] = dn_sel;
                  l_dat[log_n] = dn_dat_w;
               end
               log_n++;
            end else begin
               wcnt++;
            end
         end else begin
            wcnt = 0;
         end
         prev_stb = dn_cyc && dn_stb;
      end
   end

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // one wide access with full expectation check
   task automatic run_txn(input bit we, input logic [ADR_W-1:0] adr, input logic [7:0] sel,
                          input logic [63:0] wd, input int lat, input int eh, input string tag);
      int cyc;
      logic got_ack, got_err;
      logic [63:0] got_rd;
      int exp_n;
      int exp_h [2];
      bit stopped;
      int exp_cyc;
      logic [63:0] exp_rd;
      slv_lat = lat;
      inj_half = eh;
      log_n = 0;
      rise_n = 0;
      @(negedge clk);
      up_cyc = 1'b1; up_stb = 1'b1; up_we = we; up_adr = adr; up_sel = sel; up_dat_w = wd;
      cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (up_ack || up_err) break;
         if (cyc > 60) begin
            chk(1'b0, {tag, " watchdog R5"}, 64'(cyc), 64'd60);
            break;
         end
      end
      got_ack = up_ack; got_err = up_err; got_rd = up_dat_r;
      up_cyc = 1'b0; up_stb = 1'b0;
      @(negedge clk);
      chk(!up_ack && !up_err, {tag, " R5 single-cycle response"}, {62'd0, up_ack, up_err}, 64'd0);

      exp_n = 0; stopped = 1'b0; exp_rd = '0;
      for (int h = 0; h < 2; h++) begin
         if (!stopped && sel[h*4 +: 4] != 4'h0) begin
            exp_h[exp_n] = h;
            exp_n++;
            if (eh == h) stopped = 1'b1;
            else if (!we) exp_rd[h*32 +: 32] = rd_val({adr, h[0]});
         end
      end
      exp_cyc = 1 + exp_n * (lat + 1) + ((exp_n == 2) ? 1 : 0);

      chk(log_n == exp_n, {tag, " R1 narrow cycle count"}, 64'(log_n), 64'(exp_n));
      chk(rise_n == exp_n, {tag, " R8 strobe drops between halves"}, 64'(rise_n), 64'(exp_n));
      for (int i = 0; i < exp_n && i < log_n; i++) begin
         chk(l_adr[i] == {adr, exp_h[i][0]}, {tag, " R2 narrow address/order"},
             64'(l_adr[i]), 64'({adr, exp_h[i][0]}));
         chk(l_sel[i] == sel[exp_h[i]*4 +: 4], {tag, " R3 narrow select"},
             64'(l_sel[i]), 64'(sel[exp_h[i]*4 +: 4]));
         if (we)
            chk(l_dat[i] == wd[exp_h[i]*32 +: 32], {tag, " R3 narrow write data"},
                64'(l_dat[i]), 64'(wd[exp_h[i]*32 +: 32]));
      end
      if (exp_n == 0)
         chk(cyc == 1, {tag, " R6 empty-select latency"}, 64'(cyc), 64'd1);
      else
         chk(cyc == exp_cyc, {tag, " R5 acknowledge latency"}, 64'(cyc), 64'(exp_cyc));
      chk(got_ack == !stopped && got_err == stopped, {tag, " R7 ack/err kind"},
          {62'd0, got_ack, got_err}, {62'd0, !stopped, stopped});
      chk(got_rd == exp_rd, {tag, " R4 read lanes"}, got_rd, exp_rd);
   endtask

   task automatic t_reset();
      chk(!dn_cyc && !dn_stb && !up_ack && !up_err && up_dat_r == '0, "R9 reset state",
          {up_dat_r[63:4], dn_cyc, dn_stb, up_ack, up_err}, 64'd0);
   endtask

   task automatic t_read_full();     run_txn(1'b0, 28'h0123456, 8'hFF, 64'd0, 0, -1, "read_full");        endtask
   task automatic t_write_full();    run_txn(1'b1, 28'h00ABCDE, 8'hFF, 64'h1111_2222_3333_4444, 1, -1, "write_full"); endtask
   task automatic t_write_low();     run_txn(1'b1, 28'h0000010, 8'h0F, 64'hAAAA_BBBB_CCCC_DDDD, 1, -1, "write_low");  endtask
   task automatic t_write_high();    run_txn(1'b1, 28'h0000011, 8'hF0, 64'h0102_0304_0506_0708, 2, -1, "write_high"); endtask
   task automatic t_read_high();     run_txn(1'b0, 28'h0000777, 8'h30, 64'd0, 0, -1, "read_high");        endtask
   task automatic t_read_low();      run_txn(1'b0, 28'h0000778, 8'h01, 64'd0, 2, -1, "read_low");         endtask
   task automatic t_straddle();      run_txn(1'b1, 28'h0FFFFFF, 8'h3C, 64'hF0E1_D2C3_B4A5_9687, 0, -1, "straddle"); endtask
   task automatic t_empty();         run_txn(1'b1, 28'h0000020, 8'h00, 64'h5555_5555_5555_5555, 0, -1, "empty_sel"); endtask
   task automatic t_err_low();       run_txn(1'b0, 28'h0000030, 8'hFF, 64'd0, 1, 0, "err_low");           endtask
   task automatic t_err_high();      run_txn(1'b0, 28'h0000031, 8'hFF, 64'd0, 0, 1, "err_high");          endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_full();
      t_write_full();
      t_write_low();
      t_write_high();
      t_read_high();
      t_read_low();
      t_straddle();
      t_empty();
      t_err_low();
      t_err_high();
      t_read_full();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R5 actual=%h expected=%h", 64'd1, 64'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule